// File: doc/BRIEF.md
# Compressed Instruction Expander

This unit sits between instruction fetch and decode. It receives a 32-bit fetch word and works out whether the word holds a full-width instruction or a 16-bit compressed one. A full-width instruction is forwarded untouched, and the program counter advances by 4. A compressed instruction in the low half-word is rewritten into the base 32-bit encoding that has the same effect, and the program counter advances by 2. Decode therefore only ever sees base-format instructions.

The expansion is purely combinational and covers all three compressed quadrants. Each format's scattered immediate bits are reassembled into the matching I, S, B, J or U layout. Three-bit register fields are mapped onto x8 to x15. Encodings that are reserved or unsupported are not passed on as a plausible-looking instruction. They are replaced by an all-ones word, and the illegal flag is raised so that the pipeline can trap.

Top module: `rvc_expander`

## Requirements
- R1: When fetch bits [1:0] are 2'b11, instr_o equals the full fetch word, illegal_o is 0 and pc_step_o is 4. This holds even for the all-ones word.
- R2: When fetch bits [1:0] are not 2'b11, pc_step_o is 2 and the result depends only on fetch bits [15:0]. Bits [31:16] have no effect on it.
- R3: Any illegal compressed encoding drives instr_o to 32'hFFFFFFFF and illegal_o to 1. These encodings include quadrant 0 with funct3 (bits [15:13]) equal to 4, and the register-register group with bit 12 = 1 and bits [6:5] equal to 2 or 3.
- R4: In quadrant 0 with funct3 0, the unsigned stack-pointer offset becomes ADDI rd', x2, imm. The offset is built from bits[12:11] as imm[5:4], bits[10:7] as imm[9:6], bit 6 as imm[2] and bit 5 as imm[3], and rd' is x8 plus bits [4:2]. An offset of zero is illegal.
- R5: In quadrant 0, funct3 values 1, 2, 3, 5, 6 and 7 expand to FLD, LW, LD, FSD, SW and SD. In each case the base register is x8 plus bits [9:7] and the data register is x8 plus bits [4:2]. The word offsets take imm[5:3] from bits [12:10], imm[2] from bit 6 and imm[6] from bit 5. The double offsets take imm[7:6] from bits [6:5].
- R6: Quadrant 1 funct3 0, 1 and 2 expand to ADDI rd,rd / ADDIW rd,rd / ADDI rd,x0. In all three, rd is bits [11:7] and the sign-extended 6-bit immediate is {bit12, bits[6:2]}. With rd = 0, ADDI with a zero immediate gives 32'h00000013 and every other case is illegal.
- R7: Quadrant 1 funct3 3 with rd = 2 gives ADDI x2,x2,imm, where the immediate is a multiple of 16: imm[9] = bit 12, imm[8:7] = bits[4:3], imm[6] = bit 5, imm[5] = bit 2, imm[4] = bit 6. Any other nonzero rd gives LUI rd with a sign-extended upper immediate taken from {bit12, bits[6:2]}. A zero immediate, or rd = 0, is illegal.
- R8: Quadrant 1 funct3 4 uses bits [11:10] to select an operation on x8 plus bits [9:7]: 0 gives SRLI, 1 gives SRAI (funct7 0x20) and 2 gives ANDI. Code 3 uses {bit12, bits[6:5]} to pick SUB, XOR, OR, AND, SUBW or ADDW, with rs2 equal to x8 plus bits [4:2].
- R9: Quadrant 1 funct3 5 gives JAL x0 with the reassembled, sign-extended 12-bit offset. Funct3 6 and 7 give BEQ and BNE, comparing x8 plus bits [9:7] against x0 with a sign-extended 9-bit offset.
- R10: Quadrant 2 funct3 0, 1, 2 and 3 give SLLI rd,rd, FLD, LW and LD relative to x2. SLLI, LW and LD with rd = 0 are illegal. FLD into f0 is legal.
- R11: Quadrant 2 funct3 4 is decoded on bit 12, rs1 (bits [11:7]) and rs2 (bits [6:2]). With bit 12 = 0: rs2 = 0 gives JALR x0,0(rs1), and rs2 ≠ 0 gives ADD rs1,x0,rs2. With bit 12 = 1: both fields zero gives EBREAK 32'h00100073, rs2 = 0 gives JALR x1,0(rs1), and otherwise the result is ADD rs1,rs1,rs2. Any case with rs1 = 0 that is not EBREAK is illegal.
- R12: Quadrant 2 funct3 5, 6 and 7 give FSD, SW and SD of rs2 (bits [6:2]) at an x2-relative, zero-extended scaled offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_i | input | 32 | Fetched instruction word |
| instr_o | output | 32 | Base-format instruction, or all ones when illegal |
| illegal_o | output | 1 | Compressed encoding is reserved or unsupported |
| pc_step_o | output | 3 | Program counter increment, 2 or 4 |

## Verification
Every output is a combinational function of fetch_i, so each result is due in the same cycle in which its fetch word is applied. The driver changes fetch_i 1 ns after a rising edge and queues the expected result, computed from field-level encoders for both formats. The monitor pops and compares that result at the following falling edge, well away from the edge that moved the input. Because exactly one word is applied per cycle and the queue is drained at the same rate, each comparison always lines up with its own stimulus.

// File: rtl/rvc_exp_pkg.sv
package rvc_exp_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned CLEN   = 16;
  localparam int unsigned RW     = 5;
  localparam int unsigned STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_FULL = STEP_W'(ILEN / 8);
  localparam logic [STEP_W-1:0] STEP_HALF = STEP_W'(CLEN / 8);
  localparam logic [ILEN-1:0]   BAD_WORD  = '1;

  typedef logic [6:0] opc_t;
  localparam opc_t OPC_LOAD    = 7'b0000011;
  localparam opc_t OPC_LOAD_FP = 7'b0000111;
  localparam opc_t OPC_IMM     = 7'b0010011;
  localparam opc_t OPC_IMM32   = 7'b0011011;
  localparam opc_t OPC_STORE   = 7'b0100011;
  localparam opc_t OPC_STOREFP = 7'b0100111;
  localparam opc_t OPC_OP      = 7'b0110011;
  localparam opc_t OPC_LUI     = 7'b0110111;
  localparam opc_t OPC_OP32    = 7'b0111011;
  localparam opc_t OPC_BRANCH  = 7'b1100011;
  localparam opc_t OPC_JALR    = 7'b1100111;
  localparam opc_t OPC_JAL     = 7'b1101111;
  localparam opc_t OPC_SYSTEM  = 7'b1110011;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic            bad;
  } xres_t;

  localparam xres_t XR_BAD = '{word: BAD_WORD, bad: 1'b1};

  function automatic xres_t xr_ok(input logic [ILEN-1:0] w);
    xres_t r;
    r.word = w;
    r.bad  = 1'b0;
    return r;
  endfunction

  function automatic logic [RW-1:0] rprime(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [ILEN-1:0] f_itype(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                              input logic [2:0] f3, input logic [RW-1:0] rd, input opc_t op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] f_stype(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                              input logic [RW-1:0] rs1, input logic [2:0] f3, input opc_t op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [ILEN-1:0] f_rtype(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                              input logic [RW-1:0] rs1, input logic [2:0] f3,
                                              input logic [RW-1:0] rd, input opc_t op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  // imm passed without its always-zero bit 0
  function automatic logic [ILEN-1:0] f_btype(input logic [12:1] imm, input logic [RW-1:0] rs2,
                                              input logic [RW-1:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [ILEN-1:0] f_jtype(input logic [20:1] imm, input logic [RW-1:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [ILEN-1:0] f_utype(input logic [19:0] imm, input logic [RW-1:0] rd, input opc_t op);
    return {imm, rd, op};
  endfunction
endpackage

// File: rtl/rvc_exp_q0.sv
module rvc_exp_q0
  import rvc_exp_pkg::*;
(
  input  logic [CLEN-1:2] c_i,
  output xres_t           res_o
);
  logic [2:0]    f3;
  logic [RW-1:0] rd_p, rs1_p;
  logic [9:0]    spn_imm;
  logic [7:0]    off_d;
  logic [6:0]    off_w;

  assign f3      = c_i[15:13];
  assign rd_p    = rprime(c_i[4:2]);
  assign rs1_p   = rprime(c_i[9:7]);
  assign spn_imm = {c_i[10:7], c_i[12:11], c_i[5], c_i[6], 2'b00};
  assign off_d   = {c_i[6:5], c_i[12:10], 3'b000};
  assign off_w   = {c_i[5], c_i[12:10], c_i[6], 2'b00};

  always_comb begin
    res_o = XR_BAD;
    unique case (f3)
      3'd0: if (spn_imm != '0) res_o = xr_ok(f_itype({2'b00, spn_imm}, 5'd2, 3'd0, rd_p, OPC_IMM));
      3'd1: res_o = xr_ok(f_itype({4'd0, off_d}, rs1_p, 3'd3, rd_p, OPC_LOAD_FP));
      3'd2: res_o = xr_ok(f_itype({5'd0, off_w}, rs1_p, 3'd2, rd_p, OPC_LOAD));
      3'd3: res_o = xr_ok(f_itype({4'd0, off_d}, rs1_p, 3'd3, rd_p, OPC_LOAD));
      3'd5: res_o = xr_ok(f_stype({4'd0, off_d}, rd_p, rs1_p, 3'd3, OPC_STOREFP));
      3'd6: res_o = xr_ok(f_stype({5'd0, off_w}, rd_p, rs1_p, 3'd2, OPC_STORE));
      3'd7: res_o = xr_ok(f_stype({4'd0, off_d}, rd_p, rs1_p, 3'd3, OPC_STORE));
      default: res_o = XR_BAD;  // funct3 4 reserved
    endcase
  end
endmodule

// File: rtl/rvc_exp_q1.sv
module rvc_exp_q1
  import rvc_exp_pkg::*;
(
  input  logic [CLEN-1:2] c_i,
  output xres_t           res_o
);
  logic [2:0]    f3;
  logic [RW-1:0] rd, rd_p, rs2_p;
  logic [5:0]    imm6;
  logic [11:0]   imm12;
  logic [9:0]    sp16;
  logic [12:1]   boff;
  logic [20:1]   joff;

  assign f3    = c_i[15:13];
  assign rd    = c_i[11:7];
  assign rd_p  = rprime(c_i[9:7]);
  assign rs2_p = rprime(c_i[4:2]);
  assign imm6  = {c_i[12], c_i[6:2]};
  assign imm12 = {{6{imm6[5]}}, imm6};
  assign sp16  = {c_i[12], c_i[4:3], c_i[5], c_i[2], c_i[6], 4'b0000};
  assign boff  = {{4{c_i[12]}}, c_i[12], c_i[6:5], c_i[2], c_i[11:10], c_i[4:3]};
  assign joff  = {{9{c_i[12]}}, c_i[12], c_i[8], c_i[10:9], c_i[6], c_i[7], c_i[2], c_i[11], c_i[5:3]};

  always_comb begin
    res_o = XR_BAD;
    unique case (f3)
      3'd0: begin
        if (rd != '0)        res_o = xr_ok(f_itype(imm12, rd, 3'd0, rd, OPC_IMM));
        else if (imm6 == '0) res_o = xr_ok(f_itype('0, '0, 3'd0, '0, OPC_IMM));
      end
      3'd1: if (rd != '0) res_o = xr_ok(f_itype(imm12, rd, 3'd0, rd, OPC_IMM32));
      3'd2: if (rd != '0) res_o = xr_ok(f_itype(imm12, 5'd0, 3'd0, rd, OPC_IMM));
      3'd3: begin
        if (rd == 5'd2) begin
          if (sp16 != '0) res_o = xr_ok(f_itype({{2{sp16[9]}}, sp16}, 5'd2, 3'd0, 5'd2, OPC_IMM));
        end else if (rd != '0 && imm6 != '0) begin
          res_o = xr_ok(f_utype({{14{imm6[5]}}, imm6}, rd, OPC_LUI));
        end
      end
      3'd4: begin
        unique case (c_i[11:10])
          2'd0: res_o = xr_ok(f_itype({6'b000000, imm6}, rd_p, 3'd5, rd_p, OPC_IMM));
          2'd1: res_o = xr_ok(f_itype({6'b010000, imm6}, rd_p, 3'd5, rd_p, OPC_IMM));
          2'd2: res_o = xr_ok(f_itype(imm12, rd_p, 3'd7, rd_p, OPC_IMM));
          default: begin
            unique case ({c_i[12], c_i[6:5]})
              3'b000: res_o = xr_ok(f_rtype(7'h20, rs2_p, rd_p, 3'd0, rd_p, OPC_OP));
              3'b001: res_o = xr_ok(f_rtype(7'h00, rs2_p, rd_p, 3'd4, rd_p, OPC_OP));
              3'b010: res_o = xr_ok(f_rtype(7'h00, rs2_p, rd_p, 3'd6, rd_p, OPC_OP));
              3'b011: res_o = xr_ok(f_rtype(7'h00, rs2_p, rd_p, 3'd7, rd_p, OPC_OP));
              3'b100: res_o = xr_ok(f_rtype(7'h20, rs2_p, rd_p, 3'd0, rd_p, OPC_OP32));
              3'b101: res_o = xr_ok(f_rtype(7'h00, rs2_p, rd_p, 3'd0, rd_p, OPC_OP32));
              default: res_o = XR_BAD;
            endcase
          end
        endcase
      end
      3'd5: res_o = xr_ok(f_jtype(joff, 5'd0));
      3'd6: res_o = xr_ok(f_btype(boff, 5'd0, rd_p, 3'd0));
      default: res_o = xr_ok(f_btype(boff, 5'd0, rd_p, 3'd1));
    endcase
  end
endmodule

// File: rtl/rvc_exp_q2.sv
module rvc_exp_q2
  import rvc_exp_pkg::*;
(
  input  logic [CLEN-1:2] c_i,
  output xres_t           res_o
);
  logic [2:0]    f3;
  logic [RW-1:0] rd, rs2;
  logic [5:0]    shamt;
  logic [8:0]    ld_off, sd_off;
  logic [7:0]    lw_off, sw_off;

  assign f3     = c_i[15:13];
  assign rd     = c_i[11:7];
  assign rs2    = c_i[6:2];
  assign shamt  = {c_i[12], c_i[6:2]};
  assign ld_off = {c_i[4:2], c_i[12], c_i[6:5], 3'b000};
  assign lw_off = {c_i[3:2], c_i[12], c_i[6:4], 2'b00};
  assign sd_off = {c_i[9:7], c_i[12:10], 3'b000};
  assign sw_off = {c_i[8:7], c_i[12:9], 2'b00};

  always_comb begin
    res_o = XR_BAD;
    unique case (f3)
      3'd0: if (rd != '0) res_o = xr_ok(f_itype({6'd0, shamt}, rd, 3'd1, rd, OPC_IMM));
      3'd1: res_o = xr_ok(f_itype({3'd0, ld_off}, 5'd2, 3'd3, rd, OPC_LOAD_FP));
      3'd2: if (rd != '0) res_o = xr_ok(f_itype({4'd0, lw_off}, 5'd2, 3'd2, rd, OPC_LOAD));
      3'd3: if (rd != '0) res_o = xr_ok(f_itype({3'd0, ld_off}, 5'd2, 3'd3, rd, OPC_LOAD));
      3'd4: begin
        if (!c_i[12]) begin
          if (rd != '0) begin
            if (rs2 == '0) res_o = xr_ok(f_itype('0, rd, 3'd0, 5'd0, OPC_JALR));
            else           res_o = xr_ok(f_rtype('0, rs2, 5'd0, 3'd0, rd, OPC_OP));
          end
        end else begin
          if (rd == '0 && rs2 == '0) res_o = xr_ok(f_itype(12'd1, '0, 3'd0, '0, OPC_SYSTEM));
          else if (rd != '0) begin
            if (rs2 == '0) res_o = xr_ok(f_itype('0, rd, 3'd0, 5'd1, OPC_JALR));
            else           res_o = xr_ok(f_rtype('0, rs2, rd, 3'd0, rd, OPC_OP));
          end
        end
      end
      3'd5: res_o = xr_ok(f_stype({3'd0, sd_off}, rs2, 5'd2, 3'd3, OPC_STOREFP));
      3'd6: res_o = xr_ok(f_stype({4'd0, sw_off}, rs2, 5'd2, 3'd2, OPC_STORE));
      default: res_o = xr_ok(f_stype({3'd0, sd_off}, rs2, 5'd2, 3'd3, OPC_STORE));
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_exp_pkg::*;
(
  input  logic [ILEN-1:0]   fetch_i,
  output logic [ILEN-1:0]   instr_o,
  output logic              illegal_o,
  output logic [STEP_W-1:0] pc_step_o
);
  localparam int unsigned NQ = 3;

  xres_t q_res [NQ];
  xres_t sel;

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    if (q == 0) begin : g_q0
      rvc_exp_q0 u_q (.c_i(fetch_i[CLEN-1:2]), .res_o(q_res[q]));
    end else if (q == 1) begin : g_q1
      rvc_exp_q1 u_q (.c_i(fetch_i[CLEN-1:2]), .res_o(q_res[q]));
    end else begin : g_q2
      rvc_exp_q2 u_q (.c_i(fetch_i[CLEN-1:2]), .res_o(q_res[q]));
    end
  end

  always_comb begin
    unique case (fetch_i[1:0])
      2'd0:    sel = q_res[0];
      2'd1:    sel = q_res[1];
      2'd2:    sel = q_res[2];
      default: sel = xr_ok(fetch_i);
    endcase
  end

  assign instr_o   = sel.word;
  assign illegal_o = sel.bad;
  assign pc_step_o = (fetch_i[1:0] == 2'b11) ? STEP_FULL : STEP_HALF;
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk
  import rvc_exp_pkg::*;
(
  input logic [ILEN-1:0]   fetch_i,
  input logic [ILEN-1:0]   instr_o,
  input logic              illegal_o,
  input logic [STEP_W-1:0] pc_step_o
);
  always_comb begin
    if (!$isunknown(fetch_i)) begin
      if (fetch_i[1:0] == 2'b11) begin
        a_r1_passthrough: assert (instr_o == fetch_i && !illegal_o && pc_step_o == STEP_FULL)
          else $error("R1 full-width word altered");
      end else begin
        a_r2_half_step: assert (pc_step_o == STEP_HALF)
          else $error("R2 step not 2");
        a_r3_bad_marker: assert (illegal_o ? (instr_o == BAD_WORD)
                                           : (instr_o != BAD_WORD && instr_o[1:0] == 2'b11))
          else $error("R3 illegal flag and output disagree");
      end
      if (fetch_i[1:0] == 2'b00 && fetch_i[15:13] == 3'd0 && fetch_i[12:5] == '0) begin
        a_r4_zero_spn: assert (illegal_o) else $error("R4 zero offset accepted");
      end
      if (fetch_i[1:0] == 2'b01 && fetch_i[15:13] == 3'd3 && fetch_i[12] == 1'b0 && fetch_i[6:2] == '0) begin
        a_r7_zero_imm: assert (illegal_o) else $error("R7 zero immediate accepted");
      end
      if (fetch_i[15:0] == 16'h9002) begin
        a_r11_ebreak: assert (instr_o == 32'h00100073 && !illegal_o) else $error("R11 breakpoint");
      end
    end
  end
endmodule

bind rvc_expander rvc_expander_chk u_chk (
  .fetch_i(fetch_i), .instr_o(instr_o), .illegal_o(illegal_o), .pc_step_o(pc_step_o)
);

// File: tb/rvc_expander_tb_top.sv
module rvc_expander_tb_top;
  logic        clk = 1'b0;
  logic [31:0] fetch;
  logic [31:0] instr;
  logic        ill;
  logic [2:0]  step;

  always #5 clk = ~clk;

  rvc_expander dut_i (.fetch_i(fetch), .instr_o(instr), .illegal_o(ill), .pc_step_o(step));

  typedef struct {
    logic [31:0] f;
    logic [31:0] ei;
    logic        eb;
    logic [2:0]  es;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t cur;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [31:0] BAD = 32'hFFFF_FFFF;

  // base-format encoders
  function automatic logic [31:0] e_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return (32'(imm) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'(op);
  endfunction
  function automatic logic [31:0] e_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3, logic [6:0] op);
    return (32'(imm[11:5]) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(imm[4:0]) << 7) | 32'(op);
  endfunction
  function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return (32'(f7) << 25) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'(op);
  endfunction
  function automatic logic [31:0] e_b(logic [12:0] o, logic [4:0] rs1, logic [2:0] f3);
    return {o[12], o[10:5], 5'd0, rs1, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'b1101111};
  endfunction
  function automatic logic [31:0] e_u(logic [19:0] imm, logic [4:0] rd);
    return {imm, rd, 7'b0110111};
  endfunction

  // compressed builders
  function automatic logic [15:0] c_spn(logic [9:0] u, logic [2:0] rdp);
    return {3'b000, u[5:4], u[9:6], u[2], u[3], rdp, 2'b00};
  endfunction
  function automatic logic [15:0] c_md(logic [2:0] f3, logic [7:0] o, logic [2:0] rs1p, logic [2:0] rp);
    return {f3, o[5:3], rs1p, o[7:6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] c_mw(logic [2:0] f3, logic [6:0] o, logic [2:0] rs1p, logic [2:0] rp);
    return {f3, o[5:3], rs1p, o[2], o[6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] c_ci(logic [1:0] q, logic [2:0] f3, logic [5:0] imm, logic [4:0] rd);
    return {f3, imm[5], rd, imm[4:0], q};
  endfunction
  function automatic logic [15:0] c_sp16(logic [9:0] n);
    return {3'b011, n[9], 5'd2, n[4], n[6], n[8:7], n[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_alu(logic b12, logic [1:0] f2, logic [2:0] rp, logic [4:0] lo);
    return {3'b100, b12, f2, rp, lo, 2'b01};
  endfunction
  function automatic logic [15:0] c_jmp(logic [11:0] o);
    return {3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_br(logic [2:0] f3, logic [8:0] o, logic [2:0] rp);
    return {f3, o[8], o[4:3], rp, o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_ldsp(logic [2:0] f3, logic [8:0] o, logic [4:0] rd);
    return {f3, o[5], rd, o[4:3], o[8:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_lwsp(logic [7:0] o, logic [4:0] rd);
    return {3'b010, o[5], rd, o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_sdsp(logic [2:0] f3, logic [8:0] o, logic [4:0] rs2);
    return {f3, o[5:3], o[8:6], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] c_swsp(logic [7:0] o, logic [4:0] rs2);
    return {3'b110, o[5:2], o[7:6], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] c_cr(logic b12, logic [4:0] rs1, logic [4:0] rs2);
    return {3'b100, b12, rs1, rs2, 2'b10};
  endfunction

  task automatic drive(logic [31:0] f, logic [31:0] ei, logic eb, logic [2:0] es, string tag);
    item_t it;
    @(posedge clk);
    #1;
    fetch = f;
    it.f = f; it.ei = ei; it.eb = eb; it.es = es; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic half(logic [15:0] h, logic [31:0] ei, string tag);
    drive({16'h0000, h}, ei, 1'b0, 3'd2, tag);
  endtask

  task automatic half_bad(logic [15:0] h, string tag);
    drive({16'h0000, h}, BAD, 1'b1, 3'd2, tag);
  endtask

  // monitor: combinational result is checked half a cycle after the input moved
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      checks++;
      if (instr !== cur.ei || ill !== cur.eb || step !== cur.es) begin
        failures++;
        $display("FAIL %s fetch=%h: instr=%h exp=%h illegal=%b exp=%b step=%0d exp=%0d",
                 cur.tag, cur.f, instr, cur.ei, ill, cur.eb, step, cur.es);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog all requirements: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fetch = 32'h0;
    repeat (2) @(posedge clk);
    // reset-state style check: all-zero fetch word is the illegal zero-offset form
    half_bad(16'h0000, "R3 R4 zero word");
    // R1
    drive(32'h00A5_0533, 32'h00A5_0533, 1'b0, 3'd4, "R1 full add");
    drive(BAD, BAD, 1'b0, 3'd4, "R1 all-ones full word");
    // R2: upper bits ignored
    drive({16'hDEAD, c_spn(10'h3FC, 3'd2)}, e_i(12'h3FC, 5'd2, 3'd0, 5'd10, 7'h13), 1'b0, 3'd2, "R2 upper ignored");
    drive({16'hFFFF, c_jmp(12'h7FE)}, e_j({9'd0, 12'h7FE}), 1'b0, 3'd2, "R2 upper ignored jump");
    // R4
    half(c_spn(10'h3FC, 3'd2), e_i(12'h3FC, 5'd2, 3'd0, 5'd10, 7'h13), "R4 spn max");
    half(c_spn(10'h004, 3'd0), e_i(12'h004, 5'd2, 3'd0, 5'd8, 7'h13), "R4 spn min");
    half_bad(c_spn(10'h000, 3'd5), "R4 spn zero");
    // R5
    half(c_md(3'd1, 8'hF8, 3'd1, 3'd7), e_i(12'h0F8, 5'd9, 3'd3, 5'd15, 7'h07), "R5 fld");
    half(c_mw(3'd2, 7'h7C, 3'd2, 3'd5), e_i(12'h07C, 5'd10, 3'd2, 5'd13, 7'h03), "R5 lw");
    half(c_mw(3'd2, 7'h44, 3'd0, 3'd0), e_i(12'h044, 5'd8, 3'd2, 5'd8, 7'h03), "R5 lw scatter");
    half(c_md(3'd3, 8'h48, 3'd3, 3'd4), e_i(12'h048, 5'd11, 3'd3, 5'd12, 7'h03), "R5 ld");
    half(c_md(3'd5, 8'h88, 3'd4, 3'd6), e_s(12'h088, 5'd14, 5'd12, 3'd3, 7'h27), "R5 fsd");
    half(c_mw(3'd6, 7'h24, 3'd7, 3'd1), e_s(12'h024, 5'd9, 5'd15, 3'd2, 7'h23), "R5 sw");
    half(c_md(3'd7, 8'hC0, 3'd6, 3'd2), e_s(12'h0C0, 5'd10, 5'd14, 3'd3, 7'h23), "R5 sd");
    // R3
    half_bad({3'b100, 11'h2AB, 2'b00}, "R3 q0 funct3 4");
    half_bad(c_alu(1'b1, 2'd3, 3'd1, {2'd2, 3'd2}), "R3 rr code 2");
    half_bad(c_alu(1'b1, 2'd3, 3'd1, {2'd3, 3'd2}), "R3 rr code 3");
    // R6
    half(c_ci(2'b01, 3'd0, 6'h3F, 5'd10), e_i(12'hFFF, 5'd10, 3'd0, 5'd10, 7'h13), "R6 addi neg");
    half(c_ci(2'b01, 3'd0, 6'h00, 5'd0), 32'h0000_0013, "R6 nop");
    half_bad(c_ci(2'b01, 3'd0, 6'h05, 5'd0), "R6 addi rd0");
    half(c_ci(2'b01, 3'd1, 6'h20, 5'd5), e_i(12'hFE0, 5'd5, 3'd0, 5'd5, 7'h1B), "R6 addiw");
    half_bad(c_ci(2'b01, 3'd1, 6'h01, 5'd0), "R6 addiw rd0");
    half(c_ci(2'b01, 3'd2, 6'h1F, 5'd12), e_i(12'h01F, 5'd0, 3'd0, 5'd12, 7'h13), "R6 li");
    half_bad(c_ci(2'b01, 3'd2, 6'h01, 5'd0), "R6 li rd0");
    // R7
    half(c_sp16(10'h3F0), e_i(12'hFF0, 5'd2, 3'd0, 5'd2, 7'h13), "R7 sp16 neg");
    half(c_sp16(10'h1F0), e_i(12'h1F0, 5'd2, 3'd0, 5'd2, 7'h13), "R7 sp16 pos");
    half_bad(c_sp16(10'h000), "R7 sp16 zero");
    half(c_ci(2'b01, 3'd3, 6'h21, 5'd7), e_u(20'hFFFE1, 5'd7), "R7 lui neg");
    half(c_ci(2'b01, 3'd3, 6'h01, 5'd31), e_u(20'h00001, 5'd31), "R7 lui pos");
    half_bad(c_ci(2'b01, 3'd3, 6'h00, 5'd7), "R7 lui zero");
    half_bad(c_ci(2'b01, 3'd3, 6'h01, 5'd0), "R7 lui rd0");
    // R8
    half(c_alu(1'b1, 2'd0, 3'd1, 5'h1F), e_i({6'h00, 6'd63}, 5'd9, 3'd5, 5'd9, 7'h13), "R8 srli");
    half(c_alu(1'b0, 2'd1, 3'd0, 5'h01), e_i({6'h10, 6'd1}, 5'd8, 3'd5, 5'd8, 7'h13), "R8 srai");
    half(c_alu(1'b1, 2'd2, 3'd7, 5'h18), e_i(12'hFF8, 5'd15, 3'd7, 5'd15, 7'h13), "R8 andi");
    half(c_alu(1'b0, 2'd3, 3'd1, {2'd0, 3'd2}), e_r(7'h20, 5'd10, 5'd9, 3'd0, 5'd9, 7'h33), "R8 sub");
    half(c_alu(1'b0, 2'd3, 3'd1, {2'd1, 3'd2}), e_r(7'h00, 5'd10, 5'd9, 3'd4, 5'd9, 7'h33), "R8 xor");
    half(c_alu(1'b0, 2'd3, 3'd1, {2'd2, 3'd2}), e_r(7'h00, 5'd10, 5'd9, 3'd6, 5'd9, 7'h33), "R8 or");
    half(c_alu(1'b0, 2'd3, 3'd1, {2'd3, 3'd2}), e_r(7'h00, 5'd10, 5'd9, 3'd7, 5'd9, 7'h33), "R8 and");
    half(c_alu(1'b1, 2'd3, 3'd4, {2'd0, 3'd5}), e_r(7'h20, 5'd13, 5'd12, 3'd0, 5'd12, 7'h3B), "R8 subw");
    half(c_alu(1'b1, 2'd3, 3'd4, {2'd1, 3'd5}), e_r(7'h00, 5'd13, 5'd12, 3'd0, 5'd12, 7'h3B), "R8 addw");
    // R9
    half(c_jmp(12'h7FE), e_j({9'd0, 12'h7FE}), "R9 j fwd");
    half(c_jmp(12'h802), e_j({9'h1FF, 12'h802}), "R9 j back");
    half(c_br(3'd6, 9'h0FE, 3'd3), e_b({4'h0, 9'h0FE}, 5'd11, 3'd0), "R9 beqz");
    half(c_br(3'd7, 9'h100, 3'd0), e_b({4'hF, 9'h100}, 5'd8, 3'd1), "R9 bnez");
    // R10
    half(c_ci(2'b10, 3'd0, 6'd32, 5'd3), e_i(12'd32, 5'd3, 3'd1, 5'd3, 7'h13), "R10 slli");
    half_bad(c_ci(2'b10, 3'd0, 6'd4, 5'd0), "R10 slli rd0");
    half(c_ldsp(3'd1, 9'h1F8, 5'd0), e_i(12'h1F8, 5'd2, 3'd3, 5'd0, 7'h07), "R10 fldsp f0");
    half(c_lwsp(8'hFC, 5'd1), e_i(12'h0FC, 5'd2, 3'd2, 5'd1, 7'h03), "R10 lwsp");
    half_bad(c_lwsp(8'h04, 5'd0), "R10 lwsp rd0");
    half(c_ldsp(3'd3, 9'h038, 5'd20), e_i(12'h038, 5'd2, 3'd3, 5'd20, 7'h03), "R10 ldsp");
    half_bad(c_ldsp(3'd3, 9'h008, 5'd0), "R10 ldsp rd0");
    // R11
    half(c_cr(1'b0, 5'd5, 5'd0), e_i(12'd0, 5'd5, 3'd0, 5'd0, 7'h67), "R11 jr");
    half_bad(c_cr(1'b0, 5'd0, 5'd0), "R11 jr x0");
    half(c_cr(1'b0, 5'd6, 5'd7), e_r(7'h00, 5'd7, 5'd0, 3'd0, 5'd6, 7'h33), "R11 mv");
    half(c_cr(1'b1, 5'd0, 5'd0), 32'h0010_0073, "R11 ebreak");
    half(c_cr(1'b1, 5'd5, 5'd0), e_i(12'd0, 5'd5, 3'd0, 5'd1, 7'h67), "R11 jalr");
    half(c_cr(1'b1, 5'd6, 5'd7), e_r(7'h00, 5'd7, 5'd6, 3'd0, 5'd6, 7'h33), "R11 add");
    half_bad(c_cr(1'b1, 5'd0, 5'd7), "R11 add rd0");
    // R12
    half(c_sdsp(3'd5, 9'h1F8, 5'd8), e_s(12'h1F8, 5'd8, 5'd2, 3'd3, 7'h27), "R12 fsdsp");
    half(c_swsp(8'hFC, 5'd31), e_s(12'h0FC, 5'd31, 5'd2, 3'd2, 7'h23), "R12 swsp");
    half(c_sdsp(3'd7, 9'h048, 5'd1), e_s(12'h048, 5'd1, 5'd2, 3'd3, 7'h23), "R12 sdsp");

    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule